// File: doc/BRIEF.md
# Page Write Staging Buffer with Timed Commit

This block sits behind a serial memory command decoder. It gathers the data bytes of a write command into a staging buffer the size of one page, and it programs a behavioural byte array only when the decoder reports that chip select went high at the end of a whole byte. Once a command is accepted, the block copies the target page from the array into the buffer. This copy lets a partial write keep every byte it does not replace. Incoming bytes then land at an offset that advances inside the page and wraps back to the start of that same page. A valid commit rewrites the whole page, one byte per cycle, and holds a write-in-progress flag for a fixed number of clock cycles.

Erasing a page, a quarter-array sector or the whole array uses the same commit and busy mechanism, with every target byte set to 0xFF. A commit is dropped without trace if the write-enable permission is low, if the target is write-protected, or if chip select went high in the middle of a byte. The block raises a one-cycle pulse at the end of every busy interval so that the decoder can clear its write-enable latch. While the block is busy, array reads through the read port are refused. Data enters over a valid/ready byte stream. The sender holds `in_data` stable while `in_valid` is high and `in_ready` is low. `in_ready` is high only in the fill phase, so no byte is taken while the page is being preloaded, while a command is absent or while the block is busy.

Top module: `page_commit_unit`

## Requirements
- R1: A committed write drives `mem_we` for exactly PAGE_BYTES consecutive cycles, at ascending addresses starting from the page base. Bytes of the page that the command did not carry keep their previous values.
- R2: Data bytes are stored from the offset of the start address. The offset advances by one per byte and wraps from the last byte of the page to the first byte of the same page. Page bases are multiples of PAGE_BYTES.
- R3: A `cs_rise` with `cs_on_byte` low discards the command: the array is unchanged and `wip` stays low. The same holds for a write command that ended before any data byte arrived.
- R4: A commit is ignored, and no busy period starts, when `wel` is low or when the target is protected. `prot` encoding: 0 means nothing is protected, 1 protects addresses whose top two bits are 11, 2 protects addresses whose top bit is 1, and 3 protects everything.
- R5: After a valid commit, `wip` is high for exactly WR_CYCLES cycles for a write or a page erase, and for exactly BIG_CYCLES cycles for a sector erase or a chip erase.
- R6: `wel_clear` pulses for one cycle, in the last cycle in which `wip` is high.
- R7: A read request with `rd_en` is answered one cycle later. If `wip` was low, `rd_valid` rises with the byte on `rd_data`. If `wip` was high, `rd_refused` rises instead and `rd_valid` stays low.
- R8: `cmd_op` encoding: 0 is a write, 1 erases the page, 2 erases the quarter of the array selected by the top two address bits, and 3 erases the whole array. An erase sets every target byte to 0xFF. A chip erase is refused when `prot` is not 0.
- R9: `in_ready` is low in reset, during the page preload and while `wip` is high. A `cmd_start` that arrives while `wip` is high is ignored.
- R10: After reset, every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle pulse: a decoded command begins |
| cmd_op | input | 2 | Command kind (R8 encoding) |
| cmd_addr | input | AW | Decoded start address |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Data byte accepted this cycle when valid |
| in_data | input | 8 | Data byte |
| cs_rise | input | 1 | One-cycle pulse: chip select went high |
| cs_on_byte | input | 1 | Qualifies `cs_rise`: the rise came right after a complete byte |
| wel | input | 1 | Write-enable permission |
| prot | input | 2 | Protection level (R4 encoding) |
| wip | output | 1 | Write in progress |
| wel_clear | output | 1 | Pulse at the end of the busy interval |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_refused | output | 1 | Read refused because a write is in progress |
| rd_data | output | 8 | Read data |

## Verification
The assertions assume the following about the inputs:
- `cs_rise` is a single-cycle pulse.
- `cs_on_byte` means something only together with `cs_rise`.
- The parameters leave room for the commit sweep inside the busy window: PAGE_BYTES is at most WR_CYCLES, and the array size is at most BIG_CYCLES.

The stimulus respects these limits. It uses the default parameters and pulses `cs_rise` for exactly one cycle. It offers a data byte only after `in_ready` has risen, and it never does so in the cycle of `cs_rise`. A new command starts only after the previous busy interval has ended, except for one deliberate start issued during a busy interval. Reads are issued one at a time, so each answer can be matched to its request in order.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_PERASE = 2'd1,
    OP_SERASE = 2'd2,
    OP_CERASE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FILL,
    ST_ARMED,
    ST_PROG
  } st_e;
endpackage

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  // erased state on reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/pwb_guard.sv
module pwb_guard
  import pwb_pkg::*;
(
  input  op_e        op,
  input  logic [1:0] top2,
  input  logic [1:0] prot,
  output logic       blocked
);
  logic region_hit;

  always_comb begin
    case (prot)
      2'd1:    region_hit = (top2 == 2'b11);
      2'd2:    region_hit = top2[1];
      2'd3:    region_hit = 1'b1;
      default: region_hit = 1'b0;
    endcase
    // whole-array erase needs every region open
    blocked = (op == OP_CERASE) ? (prot != 2'd0) : region_hit;
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          busy,
  output logic          last
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            left_q <= '0;
    else if (load)         left_q <= len;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
  assign last = (left_q == CW'(1));
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit
  import pwb_pkg::*;
#(
  parameter int AW         = 10,
  parameter int PAGE_BYTES = 128,
  parameter int WR_CYCLES  = 150,
  parameter int BIG_CYCLES = 1100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          cs_rise,
  input  logic          cs_on_byte,
  input  logic          wel,
  input  logic [1:0]    prot,
  output logic          wip,
  output logic          wel_clear,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          rd_refused,
  output logic [7:0]    rd_data
);
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int MEM_BYTES  = 1 << AW;
  localparam int SECT_BYTES = MEM_BYTES / 4;
  localparam int LONGEST    = (WR_CYCLES > BIG_CYCLES) ? WR_CYCLES : BIG_CYCLES;
  localparam int CW         = $clog2(LONGEST + 1);

  st_e              state_q;
  op_e              op_q;
  logic [AW-1:0]    base_q, idx_q, last_q;
  logic [OFF_W-1:0] off_q;
  logic             got_q;
  logic [7:0]       stage_q [PAGE_BYTES];

  logic [AW-1:0] sweep_addr, span_last;
  logic [7:0]    load_byte, rd_word;
  logic [CW-1:0] busy_len;
  logic          blocked, accept_start, byte_take, commit;

  assign sweep_addr   = base_q + idx_q;
  assign accept_start = cmd_start && (state_q == ST_IDLE) && !wip;
  assign in_ready     = (state_q == ST_FILL) && !cs_rise;
  assign byte_take    = in_valid && in_ready;
  assign commit       = cs_rise && cs_on_byte && wel && !blocked &&
                        (((state_q == ST_FILL) && got_q) || (state_q == ST_ARMED));

  always_comb begin
    case (op_q)
      OP_SERASE: begin span_last = AW'(SECT_BYTES - 1); busy_len = CW'(BIG_CYCLES); end
      OP_CERASE: begin span_last = AW'(MEM_BYTES - 1);  busy_len = CW'(BIG_CYCLES); end
      default:   begin span_last = AW'(PAGE_BYTES - 1); busy_len = CW'(WR_CYCLES);  end
    endcase
  end

  pwb_array #(.AW(AW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (mem_addr),
    .wdata   (mem_wdata),
    .raddr_a (sweep_addr),
    .rdata_a (load_byte),
    .raddr_b (rd_addr),
    .rdata_b (rd_word)
  );

  pwb_guard u_guard (
    .op      (op_q),
    .top2    (base_q[AW-1:AW-2]),
    .prot    (prot),
    .blocked (blocked)
  );

  pwb_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (commit),
    .len   (busy_len),
    .busy  (wip),
    .last  (wel_clear)
  );

  // sequencing of one command
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_WRITE;
      base_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      off_q   <= '0;
      got_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_start) begin
          op_q  <= op_e'(cmd_op);
          idx_q <= '0;
          got_q <= 1'b0;
          off_q <= cmd_addr[OFF_W-1:0];
          case (op_e'(cmd_op))
            OP_WRITE: begin
              base_q  <= {cmd_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
              state_q <= ST_LOAD;
            end
            OP_PERASE: begin
              base_q  <= {cmd_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
              state_q <= ST_ARMED;
            end
            OP_SERASE: begin
              base_q  <= {cmd_addr[AW-1:AW-2], {(AW-2){1'b0}}};
              state_q <= ST_ARMED;
            end
            default: begin
              base_q  <= '0;
              state_q <= ST_ARMED;
            end
          endcase
        end
        ST_LOAD: begin
          if (cs_rise) state_q <= ST_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == AW'(PAGE_BYTES - 1)) state_q <= ST_FILL;
          end
        end
        ST_FILL, ST_ARMED: begin
          if (commit) begin
            state_q <= ST_PROG;
            idx_q   <= '0;
            last_q  <= span_last;
          end else if (cs_rise) begin
            state_q <= ST_IDLE;
          end else if (byte_take) begin
            off_q <= off_q + 1'b1;
            got_q <= 1'b1;
          end
        end
        ST_PROG: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == last_q) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // staging buffer: preload copy, then incoming bytes
  always_ff @(posedge clk) begin
    if (state_q == ST_LOAD && !cs_rise) stage_q[idx_q[OFF_W-1:0]] <= load_byte;
    else if (byte_take)                 stage_q[off_q]            <= in_data;
  end

  assign mem_we    = (state_q == ST_PROG);
  assign mem_addr  = sweep_addr;
  assign mem_wdata = (op_q == OP_WRITE) ? stage_q[idx_q[OFF_W-1:0]] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_refused <= 1'b0;
      rd_data    <= 8'h00;
    end else begin
      rd_valid   <= rd_en && !wip;
      rd_refused <= rd_en && wip;
      rd_data    <= rd_word;
    end
  end
endmodule

// File: rtl/page_commit_unit_chk.sv
module page_commit_unit_chk #(
  parameter int AW         = 10,
  parameter int WR_CYCLES  = 150,
  parameter int BIG_CYCLES = 1100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          cs_on_byte,
  input logic          in_ready,
  input logic          wip,
  input logic          wel_clear,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          rd_refused
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)   run_len <= 0;
    else if (wip) run_len <= run_len + 1;
    else          run_len <= 0;
  end

  // R9
  ready_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !in_ready);

  // R7
  read_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wip) |=> (rd_refused && !rd_valid));

  // R1
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R1
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);

  // R6
  clear_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |-> wip);

  // R6
  clear_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |=> !wip);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run_len == WR_CYCLES || run_len == BIG_CYCLES));

  // R3
  misaligned_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !cs_on_byte && !wip) |=> !wip);
endmodule

bind page_commit_unit page_commit_unit_chk #(
  .AW(AW), .WR_CYCLES(WR_CYCLES), .BIG_CYCLES(BIG_CYCLES)
) u_chk (.*);

// File: tb/page_commit_unit_bench.sv
module page_commit_unit_bench;
  localparam int AW    = 10;
  localparam int PAGE  = 128;
  localparam int WR    = 150;
  localparam int BIG   = 1100;
  localparam int MEMSZ = 1 << AW;
  localparam int SECT  = MEMSZ / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, in_valid = 0, cs_rise = 0, cs_on_byte = 0, wel = 0, rd_en = 0;
  logic [1:0] cmd_op = 0, prot = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [7:0] in_data = 0;
  logic in_ready, wip, wel_clear, mem_we, rd_valid, rd_refused;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, rd_data;

  always #10 clk = ~clk;

  page_commit_unit u_page_commit_unit (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] ref_mem [MEMSZ];
  logic [8:0] exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // scoreboard monitor for the read port
  always @(negedge clk) begin
    if (rst_n && (rd_valid || rd_refused)) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected read answer", 1, 0);
      else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_refused == e[8], {t, " refused flag"}, int'(rd_refused), int'(e[8]));
        if (!e[8]) check(rd_data == e[7:0], {t, " read data"}, int'(rd_data), int'(e[7:0]));
      end
    end
  end

  task automatic read_chk(input logic [AW-1:0] a, input string req);
    rd_en = 1; rd_addr = a;
    exp_q.push_back({wip, ref_mem[a]});
    tag_q.push_back(req);
    tick();
    rd_en = 0;
    tick();
  endtask

  task automatic start_cmd(input logic [1:0] op, input logic [AW-1:0] a);
    cmd_start = 1; cmd_op = op; cmd_addr = a;
    tick();
    cmd_start = 0;
  endtask

  task automatic end_cs(input logic aligned);
    cs_rise = 1; cs_on_byte = aligned;
    tick();
    cs_rise = 0; cs_on_byte = 0;
  endtask

  task automatic write_seq(input logic [AW-1:0] a, input int n, input logic [7:0] d0,
                           input logic aligned, input bit commits);
    int g = 0;
    start_cmd(2'd0, a);
    check(in_ready == 0, "R9 ready low in preload", int'(in_ready), 0);
    while (!in_ready && g < 400) begin tick(); g++; end
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = d0 + 8'(i);
      tick();
      in_valid = 0;
    end
    end_cs(aligned);
    if (commits)
      for (int i = 0; i < n; i++)
        ref_mem[{a[AW-1:7], 7'(a[6:0] + 7'(i))}] = d0 + 8'(i);
  endtask

  task automatic measure_busy(input int exp_len, input int exp_we, input string req);
    int cnt = 0, clr = 0, we = 0, g = 0;
    while (g < 3000) begin
      if (wip) begin
        cnt++;
        if (wel_clear) clr = cnt;
        if (mem_we) we++;
      end else if (cnt > 0 || g > 4) break;
      g++;
      tick();
    end
    check(cnt == exp_len, {req, " busy length"}, cnt, exp_len);
    check(clr == exp_len, "R6 clear pulse position", clr, exp_len);
    if (exp_we >= 0) check(we == exp_we, "R1 write strobes", we, exp_we);
  endtask

  task automatic model_fill(input int base, input int n);
    for (int i = 0; i < n; i++) ref_mem[base + i] = 8'hFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) ref_mem[i] = 8'hFF;
    repeat (3) tick();
    rst_n = 1;
    tick();
    check(wip == 0, "R9 reset wip", int'(wip), 0);
    check(in_ready == 0, "R9 reset ready", int'(in_ready), 0);
    check(mem_we == 0, "R1 reset write strobe", int'(mem_we), 0);
    read_chk(0, "R10 erased after reset");
    read_chk(1000, "R10 erased after reset");

    wel = 1;
    // three bytes into page 1
    write_seq(138, 3, 8'hA1, 1, 1);
    measure_busy(WR, PAGE, "R5 write");
    read_chk(138, "R1 written byte");
    read_chk(140, "R1 written byte");
    read_chk(137, "R1 untouched byte");
    read_chk(141, "R1 untouched byte");

    // wrap inside page 1: 254,255 then 128,129
    write_seq(254, 4, 8'hB0, 1, 1);
    measure_busy(WR, PAGE, "R5 write");
    read_chk(255, "R2 before wrap");
    read_chk(128, "R2 wrapped to page start");
    read_chk(129, "R2 wrapped to page start");
    read_chk(256, "R2 next page untouched");
    read_chk(139, "R1 earlier byte kept");

    // chip select mid-byte
    write_seq(128, 1, 8'hC0, 0, 0);
    measure_busy(0, 0, "R3 misaligned");
    read_chk(128, "R3 array unchanged");
    // no data byte at all
    write_seq(130, 0, 8'h00, 1, 0);
    measure_busy(0, 0, "R3 empty write");

    // permission off
    wel = 0;
    write_seq(200, 1, 8'h11, 1, 0);
    measure_busy(0, 0, "R4 enable low");
    read_chk(200, "R4 array unchanged");
    wel = 1;

    // top quarter protected
    prot = 2'd1;
    write_seq(900, 1, 8'h22, 1, 0);
    measure_busy(0, 0, "R4 protected page");
    read_chk(900, "R4 array unchanged");
    write_seq(300, 2, 8'h33, 1, 1);
    read_chk(301, "R7 read during busy");
    start_cmd(2'd0, 10);
    measure_busy(WR - 3, -1, "R5 write with reads");
    repeat (PAGE + 10) tick();
    check(in_ready == 0, "R9 start during busy ignored", int'(in_ready), 0);
    read_chk(300, "R4 unprotected commit");
    read_chk(301, "R4 unprotected commit");
    prot = 2'd0;

    // page erase of page 1
    start_cmd(2'd1, 150);
    end_cs(1);
    measure_busy(WR, PAGE, "R8 page erase");
    model_fill(128, PAGE);
    read_chk(129, "R8 page erased");
    read_chk(255, "R8 page erased");
    read_chk(300, "R8 other page kept");

    // sector erase of quarter 1 (256..511)
    write_seq(600, 1, 8'hD0, 1, 1);
    measure_busy(WR, PAGE, "R5 write");
    start_cmd(2'd2, 300);
    end_cs(1);
    measure_busy(BIG, SECT, "R5 sector erase");
    model_fill(256, SECT);
    read_chk(300, "R8 sector erased");
    read_chk(600, "R8 other sector kept");

    // chip erase refused under protection, then allowed
    prot = 2'd2;
    start_cmd(2'd3, 0);
    end_cs(1);
    measure_busy(0, 0, "R8 chip erase protected");
    read_chk(600, "R8 array kept");
    prot = 2'd0;
    start_cmd(2'd3, 0);
    end_cs(1);
    measure_busy(BIG, MEMSZ, "R5 chip erase");
    model_fill(0, MEMSZ);
    read_chk(600, "R8 chip erased");

    repeat (4) tick();
    check(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule